// File: doc/BRIEF.md
# Compressed Page Line-Overflow and Repack Controller

This block sits in a compressing memory controller and keeps a small metadata record for each compressed page: how many 512-byte chunks back the page, how many lines were moved into the page's inflation room, how many room bytes are still free, and the packed byte size of all lines. The packed size is the quantity from which the reclaimable space is derived. Each request is either a writeback or a metadata-cache eviction. A writeback carries the line's old and new size bins. An eviction asks whether the page is worth repacking.

For every accepted request the block returns one action code and the number of line reads and line writes that action costs. A line that grows first tries the free inflation room. If the room is too small, the block adds one chunk to the room, as long as the page is under its chunk and inflated-line limits. Only when that is not possible does it fall back to recompressing the whole page. Repacking is considered only on eviction, and only when at least one whole chunk would be released. The data path and the compressor are outside the block.

Top module: `line_ovf_repack_ctrl`

## Requirements
- R1: After reset every page record holds 8 chunks, a packed size of 4096 bytes, 0 inflated lines and 0 free room bytes. `rsp_valid` is low and `req_ready` is high.
- R2: A request accepted in cycle N (`req_valid` and `req_ready` high) produces exactly one response with `rsp_valid` high in cycle N+1.
- R3: A writeback whose new size is not larger than its old size returns action 0 (in place) with 0 reads and 1 write, and leaves the chunk count, inflated count and room unchanged.
- R4: A growing writeback returns action 1 (inflate) at a cost of 0 reads and 1 write when two conditions hold: the free room is at least the new size, and fewer than 17 lines are inflated. The room then shrinks by the new size and the inflated count rises by one.
- R5: A growing writeback that cannot inflate returns action 2 (grow room) at a cost of 0 reads and 1 write, provided the page has fewer than 8 chunks and fewer than 17 inflated lines. The chunk count rises by one, the room gains 512 minus the new size, and the inflated count rises by one.
- R6: Any other growing writeback returns action 3 (recompress) at a cost of 64 reads and 64 writes. The chunk count becomes ceil(packed/512), and the inflated count and room are cleared.
- R7: An eviction returns action 4 (repack) at a cost of 64 reads and 64 writes when ceil(packed/512) is below the chunk count. The page is then set to that chunk count, with the inflated count and room cleared. Otherwise the eviction returns action 5 (keep) at a cost of 0 reads and 0 writes and changes nothing. The bin fields are ignored on an eviction.
- R8: Size bins are encoded as 0→0 bytes, 1→8 bytes, 2→32 bytes and 3→64 bytes. Every writeback changes the page's packed size by the new bin size minus the old bin size.
- R9: A request changes only the record of the page it names.
- R10: `rsp_valid` is low in any cycle that follows a cycle with no accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 1 | 0 = writeback, 1 = metadata eviction |
| req_page | input | PAGE_W (3) | Page record index |
| req_old_bin | input | 2 | Previous size bin of the line |
| req_new_bin | input | 2 | New size bin of the line |
| rsp_valid | output | 1 | Response present |
| rsp_action | output | 3 | Action code (0 in place, 1 inflate, 2 grow room, 3 recompress, 4 repack, 5 keep) |
| rsp_reads | output | 7 | Line reads the action costs |
| rsp_writes | output | 7 | Line writes the action costs |

## Verification
The stimulus first shrinks many lines of one page and then evicts it. This separates the repack decision from the keep decision that an eviction of a fully packed page gets. It then grows lines of mixed sizes on the repacked page. That drives the room through inflation, through growth by one chunk when the room is short, and into recompression once 17 lines are inflated. A second page, still at 8 chunks, is grown to show that the chunk limit alone forces recompression. Evictions of untouched pages and idle cycles show that the records are isolated and that no response appears without a request.

// File: rtl/cmp_ovf_pkg.sv
package cmp_ovf_pkg;

    localparam int LINE_BYTES     = 64;
    localparam int LINES_PER_PAGE = 64;
    localparam int CHUNK_BYTES    = 512;
    localparam int MAX_CHUNKS     = 8;
    localparam int MAX_INFLATED   = 17;

    localparam int PAGE_BYTES  = LINE_BYTES * LINES_PER_PAGE;
    localparam int BYTE_W      = $clog2(PAGE_BYTES + 1);
    localparam int CHUNK_W     = $clog2(MAX_CHUNKS + 1);
    localparam int INFL_W      = $clog2(MAX_INFLATED + 1);
    localparam int COST_W      = $clog2(LINES_PER_PAGE + 1);
    localparam int CHUNK_SHIFT = $clog2(CHUNK_BYTES);

    typedef enum logic [1:0] {
        BIN_ZERO = 2'd0,
        BIN_8    = 2'd1,
        BIN_32   = 2'd2,
        BIN_FULL = 2'd3
    } line_bin_e;

    typedef enum logic {
        OP_WRITEBACK = 1'b0,
        OP_EVICT     = 1'b1
    } req_op_e;

    typedef enum logic [2:0] {
        ACT_IN_PLACE   = 3'd0,
        ACT_INFLATE    = 3'd1,
        ACT_GROW_ROOM  = 3'd2,
        ACT_RECOMPRESS = 3'd3,
        ACT_REPACK     = 3'd4,
        ACT_KEEP       = 3'd5
    } ovf_action_e;

    typedef struct packed {
        logic [CHUNK_W-1:0] chunks;
        logic [INFL_W-1:0]  inflated;
        logic [BYTE_W-1:0]  room_free;
        logic [BYTE_W-1:0]  packed_bytes;
    } page_meta_t;

    typedef struct packed {
        ovf_action_e       action;
        logic [COST_W-1:0] reads;
        logic [COST_W-1:0] writes;
    } ovf_result_t;

    function automatic logic [BYTE_W-1:0] bin_bytes(line_bin_e b);
        case (b)
            BIN_ZERO: return '0;
            BIN_8:    return BYTE_W'(8);
            BIN_32:   return BYTE_W'(32);
            default:  return BYTE_W'(LINE_BYTES);
        endcase
    endfunction

    function automatic logic [CHUNK_W-1:0] chunks_for(logic [BYTE_W-1:0] bytes);
        logic [BYTE_W:0] rounded;
        rounded = {1'b0, bytes} + (BYTE_W+1)'(CHUNK_BYTES - 1);
        return CHUNK_W'(rounded >> CHUNK_SHIFT);
    endfunction

    function automatic page_meta_t meta_at_reset();
        page_meta_t m;
        m.chunks       = CHUNK_W'(MAX_CHUNKS);
        m.inflated     = '0;
        m.room_free    = '0;
        m.packed_bytes = BYTE_W'(PAGE_BYTES);
        return m;
    endfunction

endpackage

// File: rtl/page_meta_table.sv
module page_meta_table
    import cmp_ovf_pkg::*;
#(
    parameter int NUM_PAGES = 8,
    localparam int PAGE_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PAGE_W-1:0] rd_page,
    output page_meta_t        rd_meta,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_page,
    input  page_meta_t        wr_meta
);

    page_meta_t entry [NUM_PAGES];

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry[p] <= meta_at_reset();
            end else if (wr_en && (wr_page == PAGE_W'(p))) begin
                entry[p] <= wr_meta;
            end
        end
    end

    assign rd_meta = entry[rd_page];

    // Limits that the decision logic must never exceed when it writes a record
    AST_CHUNK_LIMIT: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_meta.chunks <= CHUNK_W'(MAX_CHUNKS)))
        else $error("chunk count above limit"); // R5
    AST_INFL_LIMIT: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_meta.inflated <= INFL_W'(MAX_INFLATED)))
        else $error("inflated count above limit"); // R4

endmodule

// File: rtl/ovf_decide.sv
module ovf_decide
    import cmp_ovf_pkg::*;
(
    input  req_op_e     op,
    input  line_bin_e   old_bin,
    input  line_bin_e   new_bin,
    input  page_meta_t  cur,
    output ovf_result_t result,
    output page_meta_t  nxt
);

    logic [BYTE_W-1:0]  old_sz;
    logic [BYTE_W-1:0]  new_sz;
    logic [BYTE_W+1:0]  sum_sz;
    logic [BYTE_W-1:0]  packed_upd;
    logic               grows;
    logic               room_ok;
    logic               ptr_ok;
    logic               chunk_ok;
    logic [CHUNK_W-1:0] need_now;
    logic [CHUNK_W-1:0] need_upd;

    always_comb begin
        old_sz = bin_bytes(old_bin);
        new_sz = bin_bytes(new_bin);
        sum_sz = {2'b00, cur.packed_bytes} + {2'b00, new_sz};
        if (sum_sz < {2'b00, old_sz}) begin
            packed_upd = '0;
        end else if ((sum_sz - {2'b00, old_sz}) > (BYTE_W+2)'(PAGE_BYTES)) begin
            packed_upd = BYTE_W'(PAGE_BYTES);
        end else begin
            packed_upd = BYTE_W'(sum_sz - {2'b00, old_sz});
        end
        grows    = new_sz > old_sz;
        room_ok  = cur.room_free >= new_sz;
        ptr_ok   = cur.inflated < INFL_W'(MAX_INFLATED);
        chunk_ok = cur.chunks < CHUNK_W'(MAX_CHUNKS);
        need_now = chunks_for(cur.packed_bytes);
        need_upd = chunks_for(packed_upd);
    end

    always_comb begin
        nxt           = cur;
        result.action = ACT_KEEP;
        result.reads  = '0;
        result.writes = '0;
        if (op == OP_EVICT) begin
            if (need_now < cur.chunks) begin
                result.action = ACT_REPACK;
                result.reads  = COST_W'(LINES_PER_PAGE);
                result.writes = COST_W'(LINES_PER_PAGE);
                nxt.chunks    = need_now;
                nxt.inflated  = '0;
                nxt.room_free = '0;
            end
        end else begin
            nxt.packed_bytes = packed_upd;
            result.writes    = COST_W'(1);
            if (!grows) begin
                result.action = ACT_IN_PLACE;
            end else if (room_ok && ptr_ok) begin
                result.action = ACT_INFLATE;
                nxt.room_free = cur.room_free - new_sz;
                nxt.inflated  = cur.inflated + INFL_W'(1);
            end else if (chunk_ok && ptr_ok) begin
                result.action = ACT_GROW_ROOM;
                nxt.chunks    = cur.chunks + CHUNK_W'(1);
                nxt.room_free = cur.room_free + BYTE_W'(CHUNK_BYTES) - new_sz;
                nxt.inflated  = cur.inflated + INFL_W'(1);
            end else begin
                result.action = ACT_RECOMPRESS;
                result.reads  = COST_W'(LINES_PER_PAGE);
                result.writes = COST_W'(LINES_PER_PAGE);
                nxt.chunks    = need_upd;
                nxt.inflated  = '0;
                nxt.room_free = '0;
            end
        end
    end

endmodule

// File: rtl/line_ovf_repack_ctrl.sv
module line_ovf_repack_ctrl
    import cmp_ovf_pkg::*;
#(
    parameter int NUM_PAGES = 8,
    localparam int PAGE_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [1:0]        req_old_bin,
    input  logic [1:0]        req_new_bin,
    output logic              rsp_valid,
    output logic [2:0]        rsp_action,
    output logic [COST_W-1:0] rsp_reads,
    output logic [COST_W-1:0] rsp_writes
);

    logic        accept;
    page_meta_t  cur_meta;
    page_meta_t  nxt_meta;
    ovf_result_t decided;
    ovf_result_t rsp_q;
    logic        rsp_valid_q;

    assign req_ready = !rst;
    assign accept    = req_valid && req_ready;

    page_meta_table #(.NUM_PAGES(NUM_PAGES)) u_table (
        .clk     (clk),
        .rst     (rst),
        .rd_page (req_page),
        .rd_meta (cur_meta),
        .wr_en   (accept),
        .wr_page (req_page),
        .wr_meta (nxt_meta)
    );

    ovf_decide u_decide (
        .op      (req_op_e'(req_op)),
        .old_bin (line_bin_e'(req_old_bin)),
        .new_bin (line_bin_e'(req_new_bin)),
        .cur     (cur_meta),
        .result  (decided),
        .nxt     (nxt_meta)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q   <= 1'b0;
            rsp_q.action  <= ACT_KEEP;
            rsp_q.reads   <= '0;
            rsp_q.writes  <= '0;
        end else begin
            rsp_valid_q <= accept;
            if (accept) begin
                rsp_q <= decided;
            end
        end
    end

    assign rsp_valid  = rsp_valid_q;
    assign rsp_action = rsp_q.action;
    assign rsp_reads  = rsp_q.reads;
    assign rsp_writes = rsp_q.writes;

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid)
        else $error("missing response"); // R2
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !rsp_valid)
        else $error("response without request"); // R10
    AST_HEAVY_COST: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_action == 3'd3 || rsp_action == 3'd4)) |->
            (rsp_reads == COST_W'(LINES_PER_PAGE) && rsp_writes == COST_W'(LINES_PER_PAGE)))
        else $error("page-wide action cost wrong"); // R6
    AST_LIGHT_COST: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_action <= 3'd2) |-> (rsp_reads == '0 && rsp_writes == COST_W'(1)))
        else $error("single-line action cost wrong"); // R3
    AST_EVICT_KIND: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_op) |=> (rsp_action == 3'd4 || rsp_action == 3'd5))
        else $error("eviction gave a writeback action"); // R7

endmodule

// File: tb/line_ovf_repack_ctrl_test.sv
module line_ovf_repack_ctrl_test;

    localparam int PAGES = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic       req_ready;
    logic       req_op;
    logic [2:0] req_page;
    logic [1:0] req_old_bin;
    logic [1:0] req_new_bin;
    logic       rsp_valid;
    logic [2:0] rsp_action;
    logic [6:0] rsp_reads;
    logic [6:0] rsp_writes;

    always #4 clk = ~clk;

    line_ovf_repack_ctrl #(.NUM_PAGES(PAGES)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_page(req_page), .req_old_bin(req_old_bin), .req_new_bin(req_new_bin),
        .rsp_valid(rsp_valid), .rsp_action(rsp_action),
        .rsp_reads(rsp_reads), .rsp_writes(rsp_writes)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // behavioural model state
    int m_chunks [PAGES];
    int m_infl   [PAGES];
    int m_room   [PAGES];
    int m_packed [PAGES];

    bit    exp_valid = 0;
    int    exp_act, exp_rd, exp_wr;
    string exp_tag = "R10";

    function automatic int size_of(int b);
        case (b)
            0: return 0;
            1: return 8;
            2: return 32;
            default: return 64;
        endcase
    endfunction

    task automatic compare_now();
        checks++;
        if (rsp_valid !== exp_valid) begin
            errors++;
            $display("FAIL %s: rsp_valid=%0b expected %0b", exp_tag, rsp_valid, exp_valid);
        end else if (exp_valid) begin
            if (rsp_action !== 3'(exp_act) || rsp_reads !== 7'(exp_rd) || rsp_writes !== 7'(exp_wr)) begin
                errors++;
                $display("FAIL %s: action/reads/writes=%0d/%0d/%0d expected %0d/%0d/%0d",
                         exp_tag, rsp_action, rsp_reads, rsp_writes, exp_act, exp_rd, exp_wr);
            end
        end
    endtask

    // one cycle: check the previous expectation, then drive and predict
    task automatic issue(input bit op, input int page, input int ob, input int nb, input string tag);
        int os, ns, need;
        string t;
        @(negedge clk);
        compare_now();
        req_valid   = 1'b1;
        req_op      = op;
        req_page    = 3'(page);
        req_old_bin = 2'(ob);
        req_new_bin = 2'(nb);
        exp_valid = 1;
        if (op) begin
            need = (m_packed[page] + 511) / 512;
            if (need < m_chunks[page]) begin
                exp_act = 4; exp_rd = 64; exp_wr = 64;
                m_chunks[page] = need; m_infl[page] = 0; m_room[page] = 0;
            end else begin
                exp_act = 5; exp_rd = 0; exp_wr = 0;
            end
            t = "R7";
        end else begin
            os = size_of(ob); ns = size_of(nb);
            m_packed[page] += ns - os;            // R8
            exp_rd = 0; exp_wr = 1;
            if (ns <= os) begin
                exp_act = 0; t = "R3";
            end else if (m_room[page] >= ns && m_infl[page] < 17) begin
                exp_act = 1; t = "R4";
                m_room[page] -= ns; m_infl[page]++;
            end else if (m_chunks[page] < 8 && m_infl[page] < 17) begin
                exp_act = 2; t = "R5";
                m_chunks[page]++; m_room[page] += 512 - ns; m_infl[page]++;
            end else begin
                exp_act = 3; t = "R6"; exp_rd = 64; exp_wr = 64;
                m_chunks[page] = (m_packed[page] + 511) / 512;
                m_infl[page] = 0; m_room[page] = 0;
            end
        end
        exp_tag = (tag != "") ? tag : t;
    endtask

    task automatic idle_cycle(input string tag);
        @(negedge clk);
        compare_now();
        req_valid = 1'b0;
        req_op = 1'b0; req_page = '0; req_old_bin = '0; req_new_bin = '0;
        exp_valid = 0;
        exp_tag = tag;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < PAGES; p++) begin
            m_chunks[p] = 8; m_infl[p] = 0; m_room[p] = 0; m_packed[p] = 4096;
        end
        rst = 1'b1;
        req_valid = 1'b0; req_op = 1'b0; req_page = '0; req_old_bin = '0; req_new_bin = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset outputs
        checks++;
        if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1: rsp_valid=%0b req_ready=%0b expected 0/1", rsp_valid, req_ready);
        end

        // R1: a fresh page is full size, so eviction keeps it
        issue(1, 2, 3, 0, "R1");
        // R7: bins ignored on eviction
        issue(1, 3, 0, 3, "R7");
        // R3 / R8: shrink 40 full lines to zero on page 2
        for (int i = 0; i < 40; i++) issue(0, 2, 3, 0, "");
        idle_cycle("R10");
        idle_cycle("R10");
        // R7: now reclaimable, repack
        issue(1, 2, 0, 0, "");
        // R7: immediately again, nothing more to free
        issue(1, 2, 0, 0, "");
        // R5: empty room, grow by one chunk
        issue(0, 2, 0, 1, "");
        // R4: fill the room with full lines
        for (int i = 0; i < 7; i++) issue(0, 2, 0, 3, "");
        issue(0, 2, 0, 2, "");
        // R5: 32-byte line no longer fits
        issue(0, 2, 0, 2, "");
        // R4: small lines up to the inflated-line limit
        for (int i = 0; i < 7; i++) issue(0, 2, 0, 1, "");
        // R6: pointer limit reached although room is left
        issue(0, 2, 0, 1, "");
        // R3: equal size stays in place
        issue(0, 2, 1, 1, "R3");
        // R6: page at chunk limit with no room
        issue(0, 5, 3, 2, "R3");
        issue(0, 5, 2, 3, "R6");
        // R9: page 5 and untouched page 0 unaffected by page 2 traffic
        issue(1, 5, 0, 0, "R9");
        issue(1, 0, 0, 0, "R9");
        // R8: page 2 packed size seen through eviction
        issue(1, 2, 0, 0, "R8");
        // R2: back-to-back requests on different pages
        issue(0, 6, 3, 1, "R2");
        issue(0, 7, 2, 0, "R2");
        idle_cycle("R10");
        idle_cycle("R10");
        @(negedge clk);
        compare_now();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule